// File: doc/BRIEF.md
# Passive Serial Configuration Master

This block loads a configuration image into a programmable device over a passive serial link. After a `start` pulse it drives the active-low configuration request pin low for a minimum pulse. It checks that the device acknowledges by pulling its active-low status pin low. It then releases the request and polls the status pin in fixed 268 µs slices until the device lets go of it. The number of slices allowed is the family's maximum ready time divided by the slice and rounded up. After a family-specific setup gap, the block pulls image bytes from a valid/ready stream and shifts each one out on `dout`, least-significant bit first, with a generated serial clock `dclk`. The device samples `dout` on the rising edge of `dclk`, and `dout` only changes while `dclk` is low.

After the byte flagged by `in_last`, the status pin must read high. When the optional done pin is in use (`cfg_done_used`), it must read high as well. On success, one extra all-zero byte is clocked out so that the device gets the falling edges it needs to enter user mode, and then `done` is raised. A request for partial reconfiguration is refused before the pin is touched. Every failure ends with the request pin released and `error` high.

States: `S_IDLE`, `S_RST_PULSE`, `S_POLL`, `S_SETUP`, `S_FETCH`, `S_SHIFT`, `S_CHECK_END`, `S_TRAIL`, `S_DONE`, `S_FAIL`.

Transitions:
- idle/done/fail → `S_RST_PULSE` on `start`, or → `S_FAIL` on `start` with `partial_req` set.
- `S_RST_PULSE` → `S_POLL` once the pulse has elapsed with the status pin low, else → `S_FAIL`.
- `S_POLL` → `S_SETUP` at the end of a slice that sees the status pin high, or → `S_FAIL` after the last slice.
- `S_SETUP` → `S_FETCH` after the setup gap.
- `S_FETCH` → `S_SHIFT` on an accepted byte.
- `S_SHIFT` → `S_FETCH`, or → `S_CHECK_END` after the last byte.
- `S_CHECK_END` → `S_TRAIL` or → `S_FAIL`.
- `S_TRAIL` → `S_DONE` once the zero byte has gone out.

Top module: `ps_cfg_master`

## Requirements
- R1: Out of reset, `cfg_req_n` is 1 and `busy`, `done`, `error`, `in_ready`, `dclk` and `dout` are 0.
- R2: On `start`, `cfg_req_n` is held at 0 for at least 2 µs and serial clocking stays off meanwhile. If `status_n` does not read 0 at the end of that pulse, `error` rises, `cfg_req_n` returns to 1 and no `dclk` edge is produced.
- R3: `start` together with `partial_req`=1 raises `error` without ever driving `cfg_req_n` to 0.
- R4: After release, `status_n` is sampled only at the end of each 268 µs slice. The block leaves polling at the first slice end that sees `status_n`=1, never before.
- R5: At most ceil(max/268) slices are allowed, with max = 1506 µs for FAMILY 0 (6 slices) and 3000 µs for FAMILY 1 (12 slices). A release seen in the last slice still succeeds. If no slice sees a release, `error` rises about slices×268 µs after release, with `cfg_req_n`=1.
- R6: The first rising `dclk` edge comes no earlier than 2 µs (FAMILY 0) or 10 µs (FAMILY 1) after `status_n` goes high.
- R7: Each byte takes eight `dclk` pulses, and `dout` changes only while `dclk` is low, so the device's rising-edge sample gets the intended bit.
- R8: With `lsb_first`=0 (sampled at `start`), bit 0 of each `in_data` byte is sent first. With `lsb_first`=1, the byte is taken as already reversed and bit 7 is sent first.
- R9: A byte is taken when `in_valid` and `in_ready` are both 1. `in_ready` is 1 only while waiting for the next byte, and each handshake moves exactly one byte, whatever gaps the source leaves.
- R10: If `status_n` reads 0 after the last byte, `error` rises and no trailing byte is clocked.
- R11: With `cfg_done_used`=1, a 0 on `cfg_done` after the last byte raises `error`. With `cfg_done_used`=0, the `cfg_done` pin is ignored.
- R12: On success, exactly one extra byte of eight zero bits is clocked after the image, then `done` rises and `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a configuration when not busy |
| partial_req | input | 1 | Partial reconfiguration requested (refused) |
| lsb_first | input | 1 | Stream bytes are already bit-reversed |
| in_data | input | 8 | Image byte |
| in_valid | input | 1 | `in_data` holds a byte |
| in_last | input | 1 | Current byte is the final one of the image |
| in_ready | output | 1 | Block accepts a byte this cycle |
| cfg_req_n | output | 1 | Active-low configuration request to the device |
| status_n | input | 1 | Active-low status from the device |
| cfg_done | input | 1 | Configuration-done pin from the device |
| cfg_done_used | input | 1 | `cfg_done` pin is wired and must be checked |
| dclk | output | 1 | Serial clock |
| dout | output | 1 | Serial data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last sequence succeeded |
| error | output | 1 | Last sequence failed |

## Verification
The bench attacks the edges of the ready window. A release timed just before the last slice must still succeed, and a counter that is one short would reject it. A status pin that never rises must fail near 12×268 µs, and a design that stops polling too early or too late misses that window. A release halfway through a slice must not start clocking before that slice ends, which catches a design that polls continuously. Bit order is checked byte by byte with and without the pre-reversed flag, and a mix-up shows as mirrored bytes. Failures at the end of the image are checked too: a trailing zero byte appearing after an end-of-image failure, or the done pin being checked while it is marked unused, both show up as extra bytes or a wrong outcome.

// File: rtl/ps_cfg_pkg.sv
package ps_cfg_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RST_PULSE,
        S_POLL,
        S_SETUP,
        S_FETCH,
        S_SHIFT,
        S_CHECK_END,
        S_TRAIL,
        S_DONE,
        S_FAIL
    } ps_state_e;

    localparam int POLL_SLICE_US  = 268;
    localparam int RESET_PULSE_US = 2;

    // Longest time the device may hold its status low after release.
    function automatic int max_ready_us(input int fam);
        return (fam == 1) ? 3000 : 1506;
    endfunction

    // Gap between status release and the first serial clock edge.
    function automatic int setup_us(input int fam);
        return (fam == 1) ? 10 : 2;
    endfunction

    // Number of polling slices, rounded up.
    function automatic int poll_limit(input int fam);
        return (max_ready_us(fam) + POLL_SLICE_US - 1) / POLL_SLICE_US;
    endfunction

    function automatic logic [7:0] bit_rev8(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7-i];
        return r;
    endfunction

endpackage

// File: rtl/ps_pin_sync.sv
module ps_pin_sync #(
    parameter int             WIDTH     = 2,
    parameter int             STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[s] <= RESET_VAL;
            else        stg_q[s] <= (s == 0) ? d : stg_q[(s == 0) ? 0 : s-1];
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/ps_us_tick.sv
module ps_us_tick #(
    parameter int CLK_PER_US = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;

    logic [W-1:0] cnt_q;
    logic         wrap;

    assign wrap = (cnt_q == W'(CLK_PER_US - 1));
    assign tick = wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clr)    cnt_q <= '0;
        else if (wrap)   cnt_q <= '0;
        else             cnt_q <= cnt_q + W'(1);
    end
endmodule

// File: rtl/ps_bit_shifter.sv
module ps_bit_shifter #(
    parameter int SCK_HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] din,
    output logic       done,
    output logic       sck,
    output logic       sdo
);
    localparam int HW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;

    logic [HW-1:0] half_q;
    logic [2:0]    bit_q;
    logic [7:0]    sr_q;
    logic          active_q;
    logic          sck_q;
    logic          done_q;
    logic          half_end;

    assign half_end = (half_q == HW'(SCK_HALF - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q   <= '0;
            bit_q    <= '0;
            sr_q     <= '0;
            active_q <= 1'b0;
            sck_q    <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!active_q) begin
                if (load) begin
                    sr_q     <= din;
                    active_q <= 1'b1;
                    bit_q    <= '0;
                    half_q   <= '0;
                    sck_q    <= 1'b0;
                end
            end else if (half_end) begin
                half_q <= '0;
                if (!sck_q) begin
                    sck_q <= 1'b1;
                end else begin
                    sck_q <= 1'b0;
                    if (bit_q == 3'd7) begin
                        active_q <= 1'b0;
                        done_q   <= 1'b1;
                    end else begin
                        sr_q  <= sr_q >> 1;
                        bit_q <= bit_q + 3'd1;
                    end
                end
            end else begin
                half_q <= half_q + HW'(1);
            end
        end
    end

    assign sck  = sck_q;
    assign sdo  = active_q & sr_q[0];
    assign done = done_q;

    // Data may only move while the serial clock is low (R7).
    assert_data_stable_high_R7: assert property (
        @(posedge clk) disable iff (!rst_n) sck_q |-> $stable(sdo)
    );
endmodule

// File: rtl/ps_cfg_master.sv
module ps_cfg_master
    import ps_cfg_pkg::*;
#(
    parameter int CLK_PER_US = 100,
    parameter int SCK_HALF   = 2,
    parameter int FAMILY     = 0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       partial_req,
    input  logic       lsb_first,
    input  logic [7:0] in_data,
    input  logic       in_valid,
    input  logic       in_last,
    output logic       in_ready,
    output logic       cfg_req_n,
    input  logic       status_n,
    input  logic       cfg_done,
    input  logic       cfg_done_used,
    output logic       dclk,
    output logic       dout,
    output logic       busy,
    output logic       done,
    output logic       error
);
    localparam int T_ST2CK = setup_us(FAMILY);
    localparam int N_POLL  = poll_limit(FAMILY);
    localparam int US_W    = $clog2(POLL_SLICE_US + 1);
    localparam int PC_W    = $clog2(N_POLL + 1);

    ps_state_e   state_q, state_d;
    logic [US_W-1:0] us_cnt_q;
    logic [PC_W-1:0] poll_cnt_q;
    logic        last_q, lsb_q;
    logic        tick, timer_clr, timer_hit;
    int          us_target;
    logic        sh_load, sh_done;
    logic [7:0]  sh_din;
    logic [1:0]  pins_s;
    logic        stat_s, done_s;

    ps_pin_sync #(.WIDTH(2), .STAGES(2), .RESET_VAL(2'b01)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({cfg_done, status_n}), .q(pins_s)
    );
    assign stat_s = pins_s[0];
    assign done_s = pins_s[1];

    ps_us_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
        .clk(clk), .rst_n(rst_n), .clr(timer_clr), .tick(tick)
    );

    ps_bit_shifter #(.SCK_HALF(SCK_HALF)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(sh_load), .din(sh_din),
        .done(sh_done), .sck(dclk), .sdo(dout)
    );

    always_comb begin
        unique case (state_q)
            S_RST_PULSE: us_target = RESET_PULSE_US;
            S_POLL:      us_target = POLL_SLICE_US;
            S_SETUP:     us_target = T_ST2CK;
            default:     us_target = 0;
        endcase
    end
    assign timer_hit = (us_cnt_q == US_W'(us_target));
    assign timer_clr = (state_d != state_q) || (state_q == S_POLL && timer_hit);

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE, S_DONE, S_FAIL:
                if (start) state_d = partial_req ? S_FAIL : S_RST_PULSE;       // R3
            S_RST_PULSE:
                if (timer_hit) state_d = stat_s ? S_FAIL : S_POLL;             // R2
            S_POLL:
                if (timer_hit) begin                                           // R4, R5
                    if (stat_s)                                   state_d = S_SETUP;
                    else if (poll_cnt_q == PC_W'(N_POLL - 1))     state_d = S_FAIL;
                end
            S_SETUP:
                if (timer_hit) state_d = S_FETCH;                              // R6
            S_FETCH:
                if (in_valid) state_d = S_SHIFT;                               // R9
            S_SHIFT:
                if (sh_done) state_d = last_q ? S_CHECK_END : S_FETCH;
            S_CHECK_END:
                if (!stat_s || (cfg_done_used && !done_s)) state_d = S_FAIL;   // R10, R11
                else                                      state_d = S_TRAIL;
            S_TRAIL:
                if (sh_done) state_d = S_DONE;                                 // R12
            default: state_d = S_IDLE;
        endcase
    end

    // State register and sequencing state.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            us_cnt_q   <= '0;
            poll_cnt_q <= '0;
            last_q     <= 1'b0;
            lsb_q      <= 1'b0;
        end else begin
            state_q <= state_d;
            if (timer_clr)  us_cnt_q <= '0;
            else if (tick)  us_cnt_q <= us_cnt_q + US_W'(1);
            if (state_q != S_POLL)  poll_cnt_q <= '0;
            else if (timer_hit)     poll_cnt_q <= poll_cnt_q + PC_W'(1);
            if (state_q inside {S_IDLE, S_DONE, S_FAIL} && start) lsb_q <= lsb_first;  // R8
            if (state_q == S_FETCH && in_valid) last_q <= in_last;
        end
    end

    // Outputs.
    always_comb begin
        cfg_req_n = (state_q != S_RST_PULSE);
        busy      = !(state_q inside {S_IDLE, S_DONE, S_FAIL});
        done      = (state_q == S_DONE);
        error     = (state_q == S_FAIL);
        in_ready  = (state_q == S_FETCH);
        sh_load   = (state_q == S_FETCH && in_valid) ||
                    (state_q == S_CHECK_END && state_d == S_TRAIL);
        sh_din    = (state_q == S_FETCH) ? (lsb_q ? bit_rev8(in_data) : in_data) : 8'h00;
    end

    assert_no_clock_in_reset_R2: assert property (
        @(posedge clk) disable iff (!rst_n) !cfg_req_n |-> !dclk
    );
    assert_partial_rejected_R3: assert property (
        @(posedge clk) disable iff (!rst_n)
        (state_q inside {S_IDLE, S_DONE, S_FAIL} && start && partial_req) |=> (error && cfg_req_n)
    );
    assert_poll_bound_R5: assert property (
        @(posedge clk) disable iff (!rst_n) (state_q == S_POLL) |-> (poll_cnt_q < PC_W'(N_POLL))
    );
    assert_single_accept_R9: assert property (
        @(posedge clk) disable iff (!rst_n) (in_valid && in_ready) |=> !in_ready
    );
endmodule

// File: tb/ps_cfg_master_tb.sv
module ps_cfg_master_tb;
    localparam int CPU  = 4;
    localparam int HALF = 2;
    localparam int FAM  = 1;
    localparam int SLICE_CYC = 268 * CPU;
    localparam int NPOLL_EXP = (3000 + 267) / 268;   // 12 slices for FAMILY 1
    localparam int ST2CK_CYC = 10 * CPU;

    logic clk = 0, rst_n = 0;
    logic start = 0, partial_req = 0, lsb_first = 0;
    logic [7:0] in_data = 0;
    logic in_valid = 0, in_last = 0, in_ready;
    logic cfg_req_n, status_n, cfg_done = 1, cfg_done_used = 1;
    logic dclk, dout, busy, done, error;

    always #5 clk = ~clk;

    ps_cfg_master #(.CLK_PER_US(CPU), .SCK_HALF(HALF), .FAMILY(FAM)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .partial_req(partial_req),
        .lsb_first(lsb_first), .in_data(in_data), .in_valid(in_valid),
        .in_last(in_last), .in_ready(in_ready), .cfg_req_n(cfg_req_n),
        .status_n(status_n), .cfg_done(cfg_done), .cfg_done_used(cfg_done_used),
        .dclk(dclk), .dout(dout), .busy(busy), .done(done), .error(error)
    );

    // Device model controls (written by tasks only).
    bit m_no_assert = 0, m_never = 0, m_force_low = 0;
    int m_rel_cyc = 0;
    int rc = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            status_n <= 1'b1; rc <= 0;
        end else if (!cfg_req_n) begin
            status_n <= m_no_assert; rc <= 0;
        end else if (m_force_low) begin
            status_n <= 1'b0;
        end else if (!status_n) begin
            rc <= rc + 1;
            if (!m_never && rc >= m_rel_cyc) status_n <= 1'b1;
        end
    end

    // Monitor.
    longint cyc = 0, t_fall = 0, t_rise = 0, t_st = 0, t_first = 0, t_err = 0;
    int n_falls = 0, n_rises = 0, rx_n = 0, rx_bit = 0;
    logic [7:0] rx_cur = 0;
    logic [7:0] rx_mem [0:255];
    logic p_req = 1, p_st = 1, p_clk = 0, p_err = 0;
    bit armed = 0;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        p_req <= cfg_req_n; p_st <= status_n; p_clk <= dclk; p_err <= error;
        if (p_req && !cfg_req_n) begin t_fall <= cyc; n_falls <= n_falls + 1; end
        if (!p_req && cfg_req_n) t_rise <= cyc;
        if (!p_st && status_n) begin t_st <= cyc; armed <= 1; end
        if (!p_err && error) t_err <= cyc;
        if (!p_clk && dclk) begin
            n_rises <= n_rises + 1;
            if (armed) begin t_first <= cyc; armed <= 0; end
            if (rx_bit == 7) begin
                rx_mem[rx_n[7:0]] <= {dout, rx_cur[7:1]};
                rx_n <= rx_n + 1; rx_bit <= 0;
            end else begin
                rx_cur <= {dout, rx_cur[7:1]};
                rx_bit <= rx_bit + 1;
            end
        end
    end

    int n_tests = 0, n_fail = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] rev8(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7-i];
        return r;
    endfunction

    logic [7:0] img [0:15];
    bit r_done, r_err;
    int r_base, r_rises0, r_falls0;

    task automatic do_run(input int n, input bit lsb, input bit part, input int rel_us,
                          input bit no_as, input bit never, input bit end_low,
                          input bit cdu, input bit cdv, input int gap);
        int guard;
        bit acc;
        @(negedge clk);
        m_no_assert = no_as; m_never = never; m_force_low = 0;
        m_rel_cyc = rel_us * CPU; cfg_done_used = cdu; cfg_done = cdv;
        for (int i = 0; i < n; i++) img[i] = 8'($urandom);
        r_base = rx_n; r_rises0 = n_rises; r_falls0 = n_falls;
        start = 1; partial_req = part; lsb_first = lsb;
        @(negedge clk);
        start = 0; partial_req = 0;
        for (int i = 0; i < n; i++) begin
            in_valid = 0;
            repeat (gap) @(negedge clk);
            in_data = img[i]; in_valid = 1; in_last = (i == n - 1);
            acc = 0; guard = 0;
            while (!acc && !error && guard < 20000) begin
                if (in_ready) acc = 1;
                @(negedge clk);
                guard++;
            end
            in_valid = 0; in_last = 0;
            if (!acc) break;
        end
        if (end_low) m_force_low = 1;
        guard = 0;
        while (!done && !error && guard < 20000) begin @(negedge clk); guard++; end
        repeat (4) @(negedge clk);
        r_done = done; r_err = error;
    endtask

    task automatic check_bytes(input int n, input bit lsb, input string req);
        for (int i = 0; i < n; i++)
            check(rx_mem[(r_base + i) % 256] == (lsb ? rev8(img[i]) : img[i]), req,
                  rx_mem[(r_base + i) % 256], lsb ? rev8(img[i]) : img[i]);
    endtask

    initial begin
        repeat (150000) @(negedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog R12: actual hung expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: reset state
        check(cfg_req_n == 1, "R1 cfg_req_n", cfg_req_n, 1);
        check({busy, done, error, in_ready} == 4'b0, "R1 status outs", {busy, done, error, in_ready}, 0);
        check({dclk, dout} == 2'b0, "R1 serial idle", {dclk, dout}, 0);

        // Nominal run, flag clear, release in first slice
        do_run(5, 0, 0, 50, 0, 0, 0, 1, 1, 0);
        check(r_done && !r_err, "R12 done", r_done, 1);
        check_bytes(5, 0, "R8 lsb-first order / R7 sampling");
        check(rx_mem[(r_base + 5) % 256] == 8'h00, "R12 trailing zero byte", rx_mem[(r_base + 5) % 256], 0);
        check(rx_n - r_base == 6, "R12 byte count", rx_n - r_base, 6);
        check(n_rises - r_rises0 == 48, "R7 clock pulses", n_rises - r_rises0, 48);
        check(t_rise - t_fall >= 2 * CPU && t_rise - t_fall <= 2 * CPU + 8, "R2 pulse length", t_rise - t_fall, 2 * CPU);
        check(t_first - t_st >= ST2CK_CYC, "R6 setup gap", t_first - t_st, ST2CK_CYC);

        // Pre-reversed bytes, release mid second slice, source with gaps
        do_run(7, 1, 0, 300, 0, 0, 0, 1, 1, 3);
        check(r_done, "R9 done with gaps", r_done, 1);
        check_bytes(7, 1, "R8 pre-reversed order");
        check(rx_n - r_base == 8, "R9 one byte per handshake", rx_n - r_base, 8);
        check(t_first - t_rise >= 2 * SLICE_CYC + ST2CK_CYC, "R4 no early exit", t_first - t_rise, 2 * SLICE_CYC + ST2CK_CYC);
        check(t_first - t_rise <= 2 * SLICE_CYC + ST2CK_CYC + 48, "R4 exit at slice end", t_first - t_rise, 2 * SLICE_CYC + ST2CK_CYC);

        // Partial reconfiguration refused
        do_run(1, 0, 1, 50, 0, 0, 0, 1, 1, 0);
        check(r_err && !r_done, "R3 error", r_err, 1);
        check(n_falls == r_falls0, "R3 no request pulse", n_falls - r_falls0, 0);

        // Status never asserted during pulse
        do_run(2, 0, 0, 50, 1, 0, 0, 1, 1, 0);
        check(r_err, "R2 no-ack error", r_err, 1);
        check(n_rises == r_rises0, "R2 no clocks", n_rises - r_rises0, 0);
        check(cfg_req_n == 1, "R2 request released", cfg_req_n, 1);

        // Status never released: timeout
        do_run(2, 0, 0, 0, 0, 1, 0, 1, 1, 0);
        check(r_err, "R5 timeout error", r_err, 1);
        check(cfg_req_n == 1, "R5 request released", cfg_req_n, 1);
        check(t_err - t_rise >= NPOLL_EXP * SLICE_CYC && t_err - t_rise <= NPOLL_EXP * SLICE_CYC + 48,
              "R5 timeout instant", t_err - t_rise, NPOLL_EXP * SLICE_CYC);
        check(n_rises == r_rises0, "R5 no clocks", n_rises - r_rises0, 0);

        // Release inside the last allowed slice
        do_run(3, 0, 0, (NPOLL_EXP - 1) * 268 + 100, 0, 0, 0, 1, 1, 0);
        check(r_done && !r_err, "R5 last slice succeeds", r_done, 1);
        check_bytes(3, 0, "R5 data after late release");

        // Status low at end of image
        do_run(4, 0, 0, 60, 0, 0, 1, 1, 1, 0);
        check(r_err, "R10 end status error", r_err, 1);
        check(rx_n - r_base == 4, "R10 no trailing byte", rx_n - r_base, 4);
        m_force_low = 0;

        // Done pin used and low
        do_run(3, 0, 0, 60, 0, 0, 0, 1, 0, 0);
        check(r_err, "R11 done pin low error", r_err, 1);
        check(rx_n - r_base == 3, "R11 no trailing byte", rx_n - r_base, 3);

        // Done pin unused and low: ignored
        do_run(3, 0, 0, 60, 0, 0, 0, 0, 0, 0);
        check(r_done && !r_err, "R11 unused pin ignored", r_done, 1);
        check(rx_n - r_base == 4, "R11 trailing byte present", rx_n - r_base, 4);

        // Random runs
        for (int k = 0; k < 4; k++) begin
            int n = $urandom_range(1, 12);
            bit lsb = 1'($urandom_range(0, 1));
            do_run(n, lsb, 0, $urandom_range(20, 600), 0, 0, 0, 1, 1, $urandom_range(0, 4));
            check(r_done, "R12 random done", r_done, 1);
            check_bytes(n, lsb, "R8 random bytes");
            check(rx_mem[(r_base + n) % 256] == 8'h00, "R12 random trailing", rx_mem[(r_base + n) % 256], 0);
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule